// File: doc/BRIEF.md
# Dual-Clock Qualified-Port FIFO

This block is a first-in first-out buffer of 512 words, 36 bits each. A writer and a reader run on clocks that are unrelated to each other. Each port accepts or delivers a transfer only when a group of control lines decodes to a data transfer. The group is an active-low select, a mailbox select that must be low, a direction line and an enable. A port also moves data only while its own ready flag is high. The write side raises `in_rdy` while there is room for a word. The read side raises `out_rdy` while its output register holds a word that has not yet been consumed. The first stored word shows up in that register without any read request. A read then consumes the word and brings the next one forward.

Two active-low threshold flags report the fill level. `almost_empty_n` goes low when the number of stored words is no greater than the offset `x_off`. `almost_full_n` goes low when the number of free places is no greater than the offset `y_off`. The offsets come from a separate programming block and are held steady in normal use. `y_off` must be at least 1. Each data bus that would be bidirectional at the pins is brought out as its own output-enable. The port A output-enable is given here without a read data path, because the only data port A would drive is mailbox data, which this block does not hold. The single reset is active low and asynchronous. Each clock domain releases it in step with its own clock.

Top module: `qfifo_dc`

## Requirements
- R1: The buffer holds exactly 512 words and returns them in write order. After 512 writes with no reads, `in_rdy` is low, and a further qualified write attempt stores nothing.
- R2: Driving `rst_n` low forces the flag values of R3 at once, with no clock edge needed.
- R3: While reset is low, `in_rdy`=0, `out_rdy`=0, `almost_empty_n`=0 and `almost_full_n`=1. After reset the buffer is empty.
- R4: After `rst_n` rises, `in_rdy` stays low through at least the first two rising `wclk` edges, and then rises.
- R5: A word is stored on a rising `wclk` edge only when `a_cs_n`=0, `a_mbx_sel`=0, `a_dir`=1, `a_en`=1 and `in_rdy`=1. Any other combination stores nothing.
- R6: A word is consumed on a rising `rclk` edge only when `b_cs_n`=0, `b_mbx_sel`=0, `b_dir`=1, `b_en`=1 and `out_rdy`=1. While no word is consumed, `out_rdy` and `b_q` hold.
- R7: `a_oe`=1 exactly when `a_cs_n`=0 and `a_dir`=0. `b_oe`=1 exactly when `b_cs_n`=0 and `b_dir`=1.
- R8: Writes and reads may happen in the same period of time with no loss, duplication or reordering of words.
- R9: `almost_empty_n` is low exactly when the stored count (the word in the output register included) is no greater than `x_off`.
- R10: `almost_full_n` is low exactly when 512 minus the stored count is no greater than `y_off`.
- R11: `out_rdy` rises, with the oldest word in `b_q`, without any read request. It falls only after the last stored word has been consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_off | input | 9 | Almost-empty offset |
| y_off | input | 9 | Almost-full offset (at least 1) |
| a_cs_n | input | 1 | Port A select, active low |
| a_mbx_sel | input | 1 | Port A mailbox select, must be low to write |
| a_dir | input | 1 | Port A direction, 1 = write |
| a_en | input | 1 | Port A enable |
| a_din | input | 36 | Write data |
| a_oe | output | 1 | Port A bus output-enable |
| in_rdy | output | 1 | Room for a word |
| almost_full_n | output | 1 | Low when free places <= y_off |
| b_cs_n | input | 1 | Port B select, active low |
| b_mbx_sel | input | 1 | Port B mailbox select, must be low to read |
| b_dir | input | 1 | Port B direction, 1 = read |
| b_en | input | 1 | Port B enable |
| b_q | output | 36 | Output register holding the oldest word |
| b_oe | output | 1 | Port B bus output-enable |
| out_rdy | output | 1 | `b_q` holds an unread word |
| almost_empty_n | output | 1 | Low when stored count <= x_off |

## Verification
The thresholds are tried with fill levels placed one word each side of `x_off` and `y_off`, and exactly on them. This tells an off-by-one comparison apart from a correct one, and shows whether the word held in the output register is counted. A full fill followed by one extra qualified write shows both the capacity and the refusal on overflow. Each control line of each port is then disabled on its own while the rest stay valid, which proves that every term of the five-way decode takes part. A run where words are written and read in the same period checks ordering across the clock crossing. A reset applied between clock edges shows that the flags respond to reset without a clock.

// File: rtl/qfifo_pkg.sv
package qfifo_pkg;

  typedef struct packed {
    logic sel_n;
    logic mbx;
    logic dir;
    logic en;
  } port_ctl_t;

  // Data transfer decode shared by both ports (dir high means "move data")
  function automatic logic xfer_req(port_ctl_t c);
    return !c.sel_n && !c.mbx && c.dir && c.en;
  endfunction

  function automatic logic [31:0] gray2bin32(logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/qfifo_rst_sync.sv
module qfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg <= 2'b00;
    else         stg <= {stg[0], 1'b1};
  end

  assign srst_n = stg[1];
endmodule

// File: rtl/qfifo_sync.sv
module qfifo_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qfifo_wr_ctl.sv
module qfifo_wr_ctl
  import qfifo_pkg::*;
#(
  parameter int ADDR_W = 9,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [PTR_W-1:0]  rgray_s,
  input  logic [ADDR_W-1:0] y_off,
  output logic              wr_en,
  output logic [ADDR_W-1:0] waddr,
  output logic [PTR_W-1:0]  wgray,
  output logic              in_rdy,
  output logic              af_n,
  output logic [PTR_W-1:0]  level
);
  localparam logic [PTR_W-1:0] DEPTH = PTR_W'(1) << ADDR_W;

  logic [PTR_W-1:0] wbin, wbin_nx, rbin_s, used_nx, free_nx;
  logic [31:0]      rconv;
  logic             in_rdy_nx, af_n_nx;

  always_comb begin
    wr_en     = req && in_rdy;
    rconv     = gray2bin32(32'(rgray_s));
    rbin_s    = rconv[PTR_W-1:0];
    wbin_nx   = wbin + PTR_W'(wr_en);
    used_nx   = wbin_nx - rbin_s;
    free_nx   = DEPTH - used_nx;
    in_rdy_nx = (used_nx != DEPTH);
    af_n_nx   = (free_nx > {1'b0, y_off});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      in_rdy <= 1'b0;
      af_n   <= 1'b1;
    end else begin
      if (wr_en) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
      in_rdy <= in_rdy_nx;
      af_n   <= af_n_nx;
    end
  end

  assign waddr = wbin[ADDR_W-1:0];
  assign level = wbin - rbin_s;
endmodule

// File: rtl/qfifo_rd_ctl.sv
module qfifo_rd_ctl
  import qfifo_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 36,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [PTR_W-1:0]  wgray_s,
  input  logic [ADDR_W-1:0] x_off,
  input  logic [DATA_W-1:0] mem_q,
  output logic [ADDR_W-1:0] raddr,
  output logic [PTR_W-1:0]  rgray,
  output logic              out_rdy,
  output logic              ae_n,
  output logic [DATA_W-1:0] q
);
  logic [PTR_W-1:0] rbin, rbin_nx, wbin_s, words_nx;
  logic [31:0]      wconv;
  logic             take, load;

  always_comb begin
    take     = req && out_rdy;
    wconv    = gray2bin32(32'(wgray_s));
    wbin_s   = wconv[PTR_W-1:0];
    rbin_nx  = rbin + PTR_W'(take);
    words_nx = wbin_s - rbin_nx;
    load     = (take || !out_rdy) && (words_nx != '0);
    raddr    = rbin_nx[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      out_rdy <= 1'b0;
      ae_n    <= 1'b0;
      q       <= '0;
    end else begin
      if (take) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
      out_rdy <= (words_nx != '0);
      ae_n    <= (words_nx > {1'b0, x_off});
      if (load) q <= mem_q;
    end
  end
endmodule

// File: rtl/qfifo_dc.sv
module qfifo_dc
  import qfifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 9
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] x_off,
  input  logic [ADDR_W-1:0] y_off,
  input  logic              a_cs_n,
  input  logic              a_mbx_sel,
  input  logic              a_dir,
  input  logic              a_en,
  input  logic [DATA_W-1:0] a_din,
  output logic              a_oe,
  output logic              in_rdy,
  output logic              almost_full_n,
  input  logic              b_cs_n,
  input  logic              b_mbx_sel,
  input  logic              b_dir,
  input  logic              b_en,
  output logic [DATA_W-1:0] b_q,
  output logic              b_oe,
  output logic              out_rdy,
  output logic              almost_empty_n
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic              wrst_n, rrst_n;
  port_ctl_t         a_ctl, b_ctl;
  logic              wr_en;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s, w_level;
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] mem [DEPTH];

  assign a_ctl = '{sel_n: a_cs_n, mbx: a_mbx_sel, dir: a_dir, en: a_en};
  assign b_ctl = '{sel_n: b_cs_n, mbx: b_mbx_sel, dir: b_dir, en: b_en};
  assign a_oe  = !a_cs_n && !a_dir;
  assign b_oe  = !b_cs_n && b_dir;

  qfifo_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wrst_n));
  qfifo_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rrst_n));

  qfifo_sync #(.W(PTR_W), .STAGES(2)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  qfifo_sync #(.W(PTR_W), .STAGES(2)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  qfifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .req(xfer_req(a_ctl)), .rgray_s(rgray_s),
    .y_off(y_off), .wr_en(wr_en), .waddr(waddr), .wgray(wgray),
    .in_rdy(in_rdy), .af_n(almost_full_n), .level(w_level));

  always_ff @(posedge wclk) begin
    if (wr_en) mem[waddr] <= a_din;
  end

  assign mem_q = mem[raddr];

  qfifo_rd_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(rclk), .rst_n(rrst_n), .req(xfer_req(b_ctl)), .wgray_s(wgray_s),
    .x_off(x_off), .mem_q(mem_q), .raddr(raddr), .rgray(rgray),
    .out_rdy(out_rdy), .ae_n(almost_empty_n), .q(b_q));
endmodule

// File: rtl/qfifo_dc_chk.sv
module qfifo_dc_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 36,
  localparam int PTR_W = ADDR_W + 1
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst_n,
  input logic              in_rdy,
  input logic              out_rdy,
  input logic              almost_empty_n,
  input logic              almost_full_n,
  input logic              b_cs_n,
  input logic              b_mbx_sel,
  input logic              b_dir,
  input logic              b_en,
  input logic [DATA_W-1:0] b_q,
  input logic [PTR_W-1:0]  w_level
);
  localparam logic [PTR_W-1:0] CAP = PTR_W'(1) << ADDR_W;

  logic take;
  assign take = !b_cs_n && !b_mbx_sel && b_dir && b_en && out_rdy;

  assert_no_overflow_R1: assert property (@(posedge wclk) disable iff (!rst_n)
    w_level <= CAP);

  assert_ir_late_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    $rose(in_rdy) |-> ($past(rst_n) && $past(rst_n, 2)));

  assert_hold_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    (out_rdy && !take) |=> (out_rdy && $stable(b_q)));

  assert_empty_flag_R9: assert property (@(posedge rclk) disable iff (!rst_n)
    !out_rdy |-> !almost_empty_n);

  assert_full_flag_R10: assert property (@(posedge wclk) disable iff (!rst_n)
    $fell(in_rdy) |-> !almost_full_n);

  assert_last_read_R11: assert property (@(posedge rclk) disable iff (!rst_n)
    $fell(out_rdy) |-> $past(take));
endmodule

bind qfifo_dc qfifo_dc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_qfifo_dc.sv
module tb_qfifo_dc;
  localparam int DW = 36;
  localparam int AW = 9;

  logic wclk, rclk, rst_n;
  logic [AW-1:0] x_off, y_off;
  logic a_cs_n, a_mbx_sel, a_dir, a_en, a_oe, in_rdy, almost_full_n;
  logic [DW-1:0] a_din, b_q;
  logic b_cs_n, b_mbx_sel, b_dir, b_en, b_oe, out_rdy, almost_empty_n;

  int n_checks = 0;
  int n_err    = 0;

  qfifo_dc #(.DATA_W(DW), .ADDR_W(AW)) dut (.*);

  initial begin wclk = 0; forever #4 wclk = ~wclk; end
  initial begin rclk = 0; #3; forever #4 rclk = ~rclk; end

  typedef struct packed {
    logic [8:0] x;
    logic [8:0] y;
    logic [9:0] n;
    logic       ae_n;
    logic       af_n;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{9'd8,   9'd8,  10'd1,   1'b0, 1'b1},
    '{9'd8,   9'd8,  10'd8,   1'b0, 1'b1},
    '{9'd8,   9'd8,  10'd9,   1'b1, 1'b1},
    '{9'd64,  9'd64, 10'd447, 1'b1, 1'b1},
    '{9'd64,  9'd64, 10'd448, 1'b1, 1'b0},
    '{9'd4,   9'd1,  10'd511, 1'b1, 1'b0},
    '{9'd508, 9'd4,  10'd508, 1'b0, 1'b0},
    '{9'd508, 9'd4,  10'd509, 1'b1, 1'b0}
  };

  function automatic logic [DW-1:0] pat(int tag, int i);
    return {4'(tag), 32'(i) * 32'h9E3779B1 + 32'(tag)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic a_idle();
    a_cs_n = 1; a_mbx_sel = 0; a_dir = 1; a_en = 0;
  endtask

  task automatic b_idle();
    b_cs_n = 1; b_mbx_sel = 0; b_dir = 1; b_en = 0;
  endtask

  task automatic settle();
    repeat (10) @(negedge wclk);
  endtask

  task automatic do_reset();
    @(negedge wclk);
    rst_n = 0;
    a_idle(); b_idle();
    repeat (6) @(posedge wclk);
    @(negedge wclk);
    rst_n = 1;
    for (int t = 0; t < 20 && !in_rdy; t++) @(negedge wclk);
  endtask

  task automatic push(input int n, input int tag);
    int i = 0;
    while (i < n) begin
      @(negedge wclk);
      if (in_rdy) begin
        a_cs_n = 0; a_mbx_sel = 0; a_dir = 1; a_en = 1;
        a_din = pat(tag, i);
        i++;
      end else begin
        a_idle();
      end
    end
    @(negedge wclk);
    a_idle();
  endtask

  task automatic pop(input int n, input int tag, output int bad);
    int i = 0;
    bad = 0;
    while (i < n) begin
      @(negedge rclk);
      if (out_rdy) begin
        if (b_q !== pat(tag, i)) bad++;
        b_cs_n = 0; b_mbx_sel = 0; b_dir = 1; b_en = 1;
        i++;
      end else begin
        b_idle();
      end
    end
    @(negedge rclk);
    b_idle();
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int bad;
    logic [DW-1:0] held;
    rst_n = 0;
    x_off = 9'd8; y_off = 9'd8;
    a_din = '0;
    a_idle(); b_idle();

    // R3: flag values while reset is held
    repeat (6) @(posedge wclk);
    #1;
    check(in_rdy == 0, "R3 in_rdy", 64'(in_rdy), 0);
    check(out_rdy == 0, "R3 out_rdy", 64'(out_rdy), 0);
    check(almost_empty_n == 0, "R3 almost_empty_n", 64'(almost_empty_n), 0);
    check(almost_full_n == 1, "R3 almost_full_n", 64'(almost_full_n), 1);

    // R4: in_rdy late after release
    @(negedge wclk);
    rst_n = 1;
    @(negedge wclk);
    check(in_rdy == 0, "R4 in_rdy after first edge", 64'(in_rdy), 0);
    repeat (5) @(negedge wclk);
    check(in_rdy == 1, "R4 in_rdy later", 64'(in_rdy), 1);

    // R7: output-enable decodes
    for (int c = 0; c < 4; c++) begin
      a_cs_n = c[1]; a_dir = c[0];
      b_cs_n = c[1]; b_dir = c[0];
      #1;
      check(a_oe == (c == 0), "R7 a_oe", 64'(a_oe), 64'(c == 0));
      check(b_oe == (c == 1), "R7 b_oe", 64'(b_oe), 64'(c == 1));
    end
    a_idle(); b_idle();

    // R5: each write qualifier disabled alone stores nothing
    for (int c = 0; c < 4; c++) begin
      @(negedge wclk);
      a_cs_n = (c == 0); a_mbx_sel = (c == 1); a_dir = (c != 2); a_en = (c != 3);
      a_din = pat(1, 0);
      @(negedge wclk);
      a_idle();
      settle();
      check(out_rdy == 0, "R5 disabled write qualifier", 64'(out_rdy), 0);
    end
    push(1, 2);
    settle();
    check(out_rdy == 1 && b_q == pat(2, 0), "R11 first word presented", 64'(b_q), 64'(pat(2, 0)));

    // R6: each read qualifier disabled alone consumes nothing
    held = b_q;
    for (int c = 0; c < 4; c++) begin
      @(negedge rclk);
      b_cs_n = (c == 0); b_mbx_sel = (c == 1); b_dir = (c != 2); b_en = (c != 3);
      repeat (2) @(negedge rclk);
      b_idle();
      settle();
      check(out_rdy == 1 && b_q == held, "R6 disabled read qualifier", 64'(b_q), 64'(held));
    end
    pop(1, 2, bad);
    check(bad == 0, "R6 qualified read", 64'(bad), 0);
    settle();
    check(out_rdy == 0, "R11 out_rdy after last read", 64'(out_rdy), 0);

    // R9/R10/R11 threshold table
    for (int k = 0; k < NVEC; k++) begin
      x_off = VEC[k].x; y_off = VEC[k].y;
      do_reset();
      push(int'(VEC[k].n), k);
      settle();
      check(almost_empty_n == VEC[k].ae_n, "R9 almost_empty_n at level", 64'(almost_empty_n), 64'(VEC[k].ae_n));
      check(almost_full_n == VEC[k].af_n, "R10 almost_full_n at level", 64'(almost_full_n), 64'(VEC[k].af_n));
      check(in_rdy == 1 && out_rdy == 1, "R11 ready flags with data", {in_rdy, out_rdy}, 2'b11);
      pop(int'(VEC[k].n), k, bad);
      check(bad == 0, "R8 data order in table", 64'(bad), 0);
      settle();
      check(out_rdy == 0 && almost_empty_n == 0, "R9 flags when drained", {out_rdy, almost_empty_n}, 0);
      check(almost_full_n == 1, "R10 almost_full_n when drained", 64'(almost_full_n), 1);
    end

    // R1: capacity and refusal when full
    x_off = 9'd4; y_off = 9'd1;
    do_reset();
    push(512, 11);
    settle();
    check(in_rdy == 0, "R1 in_rdy low when full", 64'(in_rdy), 0);
    @(negedge wclk);
    a_cs_n = 0; a_mbx_sel = 0; a_dir = 1; a_en = 1; a_din = '1;
    repeat (3) @(negedge wclk);
    a_idle();
    settle();
    pop(512, 11, bad);
    check(bad == 0, "R1 512 words in order", 64'(bad), 0);
    settle();
    check(out_rdy == 0, "R1 no extra word stored", 64'(out_rdy), 0);

    // R8: concurrent writing and reading
    x_off = 9'd8; y_off = 9'd8;
    do_reset();
    fork
      push(300, 12);
      pop(300, 12, bad);
    join
    check(bad == 0, "R8 concurrent transfer order", 64'(bad), 0);
    settle();
    check(out_rdy == 0 && in_rdy == 1, "R8 flags after concurrent run", {out_rdy, in_rdy}, 2'b01);

    // R2: reset between clock edges acts at once
    push(5, 13);
    settle();
    @(negedge wclk);
    #1 rst_n = 0;
    #1;
    check(in_rdy == 0 && out_rdy == 0, "R2 ready flags on async reset", {in_rdy, out_rdy}, 0);
    check(almost_empty_n == 0 && almost_full_n == 1, "R2 threshold flags on async reset",
          {almost_empty_n, almost_full_n}, 2'b01);
    repeat (6) @(posedge wclk);
    @(negedge wclk);
    rst_n = 1;
    settle();
    check(out_rdy == 0 && in_rdy == 1, "R3 empty after reset", {out_rdy, in_rdy}, 2'b01);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule